// File: doc/BRIEF.md
# Bipolar Receive Output Formatter

This block sits behind a line receiver that has already recovered the bit clock and sliced the incoming signal into two pulse indications per bit period: one for a positive mark and one for a negative mark. It presents the received stream on a single pair of output lanes whose meaning depends on a mode input. In pass-through (bipolar) mode the lanes carry the positive and negative marks unchanged. In decoded (binary) mode lane A carries NRZ data with zero-substitution codes removed, and lane B marks line-code faults. The zero-substitution code is the three-zero code of the 44.736 and 51.840 Mb/s rates, or the four-zero code of the 34.368 Mb/s rate, chosen by `e3_mode`.

All decoding runs through a fixed four-symbol pipeline, so a substitution can be recognised when its violation pulse arrives and its earlier balancing pulse can still be cancelled. The formatted result is launched on the falling clock edge or, when `clk_inv` is set, on the rising edge. An active-low enable drives per-lane output-enable signals for the two data lanes and for the forwarded clock. The decoder keeps running while the outputs are disabled.

A polarity tracker holds the sign of the last single mark. Its states are `POL_NONE` (no mark seen since reset), `POL_POS` and `POL_NEG`. From any state, a lone positive mark moves it to `POL_POS` and a lone negative mark moves it to `POL_NEG`. A bit with no mark, or with both marks at once, leaves it where it is. A lone mark whose sign matches the state counts as a bipolar violation. In `POL_NONE` no mark counts as a violation.

Top module: `bipolar_rx_formatter`

## Requirements
- R1: With `bin_mode`=0 and `clk_inv`=0, `lane_a` equals `rx_pos` and `lane_b` equals `rx_neg` as sampled at the rising edge four cycles earlier.
- R2: With `bin_mode`=1, a bit with no mark always gives `lane_a`=0, and a bit with a mark gives `lane_a`=1 unless the mark belongs to a recognised substitution.
- R3: With `e3_mode`=0, a violation directly preceded by an empty bit is a valid substitution: the violation bit and the bit two places before it leave as 0, with no flag.
- R4: With `e3_mode`=1, a violation preceded by two empty bits is a valid substitution: the violation bit and the bit three places before it leave as 0, with no flag.
- R5: A violation that is not a valid substitution leaves as `lane_a`=1 with `lane_b`=1. A flagged bit is never cancelled, so `lane_b`=1 implies `lane_a`=1 in binary mode.
- R6: A bit with both marks high leaves as `lane_a`=1 and `lane_b`=1, and it does not change the polarity tracker.
- R7: With `clk_inv`=0 the lanes change on the falling edge, with a latency of four cycles plus a half cycle. With `clk_inv`=1 they change on the rising edge, one half cycle later.
- R8: `lane_a_oe`, `lane_b_oe` and `clk_oe` equal the inverse of `out_en_n`. Decoding and polarity tracking continue while they are low.
- R9: Reset clears the pipeline, the output registers and the tracker (to `POL_NONE`), so the lanes read 0 after reset and the first mark after reset is never a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos | input | 1 | Positive mark seen in this bit period |
| rx_neg | input | 1 | Negative mark seen in this bit period |
| bin_mode | input | 1 | 0 = pass-through lanes, 1 = decoded data and fault flag |
| e3_mode | input | 1 | 0 = three-zero substitution code, 1 = four-zero substitution code |
| clk_inv | input | 1 | 0 = launch on falling edge, 1 = launch on rising edge |
| out_en_n | input | 1 | Active-low output enable |
| lane_a | output | 1 | Positive marks or decoded data |
| lane_b | output | 1 | Negative marks or code-fault flag |
| lane_a_oe | output | 1 | Drive enable for lane A |
| lane_b_oe | output | 1 | Drive enable for lane B |
| clk_out | output | 1 | Forwarded bit clock |
| clk_oe | output | 1 | Drive enable for the forwarded clock |

## Verification
On every cycle, the assertions check the pass-through relation between inputs and lanes, that empty bits never decode to ones, that double marks always come out flagged, that a flag never sits on a zero bit, the enable relation and the cleared lanes after reset. Only the bench scenarios can show that substitutions are cancelled correctly in each code, including the earlier balancing pulse, that the same pattern is valid in one code and faulty in the other, and that the tracker ignores double marks. They also show that the rising-edge option adds its half cycle, and that state built up while outputs are disabled shapes later decoding.

// File: rtl/bprx_pkg.sv
`timescale 1ns/1ps
package bprx_pkg;

    localparam int SPAN_THREE = 3;
    localparam int SPAN_FOUR  = 4;
    localparam int PIPE_DEPTH = (SPAN_FOUR > SPAN_THREE) ? SPAN_FOUR : SPAN_THREE;
    localparam int BAL_IDX_THREE = SPAN_THREE - 2;
    localparam int BAL_IDX_FOUR  = SPAN_FOUR - 2;
    localparam int LANE_COUNT = 2;

    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } pol_state_e;

    typedef struct packed {
        logic dat;
        logic flg;
        logic rp;
        logic rn;
    } stage_t;

endpackage

// File: rtl/bprx_polarity.sv
`timescale 1ns/1ps
module bprx_polarity
    import bprx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sym_pos,
    input  logic sym_neg,
    output logic viol
);

    pol_state_e state_q;
    pol_state_e state_d;
    logic       lone_pos;
    logic       lone_neg;

    assign lone_pos = sym_pos && !sym_neg;
    assign lone_neg = sym_neg && !sym_pos;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= POL_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: lone marks move the tracker, anything else holds it
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POL_NONE,
            POL_POS,
            POL_NEG: begin
                if (lone_pos) begin
                    state_d = POL_POS;
                end else if (lone_neg) begin
                    state_d = POL_NEG;
                end
            end
            default: state_d = POL_NONE;
        endcase
    end

    // output: a lone mark repeating the tracked sign is a violation
    always_comb begin
        viol = 1'b0;
        unique case (state_q)
            POL_NONE: viol = 1'b0;
            POL_POS:  viol = lone_pos;
            POL_NEG:  viol = lone_neg;
            default:  viol = 1'b0;
        endcase
    end

endmodule

// File: rtl/bprx_decode.sv
`timescale 1ns/1ps
module bprx_decode
    import bprx_pkg::*;
#(
    parameter int DEPTH     = PIPE_DEPTH,
    parameter int BAL_THREE = BAL_IDX_THREE,
    parameter int BAL_FOUR  = BAL_IDX_FOUR
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   e3_mode,
    input  logic   sym_pos,
    input  logic   sym_neg,
    input  logic   viol,
    output stage_t tail
);

    stage_t pipe_q [DEPTH];
    stage_t pipe_d [DEPTH];

    logic has_mark;
    logic both_marks;
    logic prior1_empty;
    logic prior2_empty;
    logic sub_ok;
    int   bal_idx;

    always_comb begin
        has_mark     = sym_pos || sym_neg;
        both_marks   = sym_pos && sym_neg;
        prior1_empty = !(pipe_q[0].rp || pipe_q[0].rn);
        prior2_empty = !(pipe_q[1].rp || pipe_q[1].rn);
        sub_ok       = viol && prior1_empty && (!e3_mode || prior2_empty);
        bal_idx      = e3_mode ? BAL_FOUR : BAL_THREE;

        pipe_d[0].dat = has_mark && !sub_ok;
        pipe_d[0].flg = both_marks || (viol && !sub_ok);
        pipe_d[0].rp  = sym_pos;
        pipe_d[0].rn  = sym_neg;

        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
            // cancel the balancing mark of a substitution, never a flagged bit
            if (sub_ok && ((i - 1) == bal_idx) && !pipe_q[i-1].flg) begin
                pipe_d[i].dat = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    assign tail = pipe_q[DEPTH-1];

endmodule

// File: rtl/bprx_edge_out.sv
`timescale 1ns/1ps
module bprx_edge_out #(
    parameter int WIDTH = bprx_pkg::LANE_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_inv,
    input  logic             out_en_n,
    input  logic [WIDTH-1:0] fmt,
    output logic [WIDTH-1:0] lanes,
    output logic [WIDTH-1:0] lanes_oe,
    output logic             clk_fwd,
    output logic             clk_fwd_oe
);

    logic [WIDTH-1:0] fall_q;
    logic [WIDTH-1:0] rise_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= fmt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
        end else begin
            rise_q <= fmt;
        end
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_lane
            assign lanes[g]    = clk_inv ? rise_q[g] : fall_q[g];
            assign lanes_oe[g] = !out_en_n;
        end
    endgenerate

    assign clk_fwd    = clk;
    assign clk_fwd_oe = !out_en_n;

endmodule

// File: rtl/bipolar_rx_formatter.sv
`timescale 1ns/1ps
module bipolar_rx_formatter
    import bprx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic bin_mode,
    input  logic e3_mode,
    input  logic clk_inv,
    input  logic out_en_n,
    output logic lane_a,
    output logic lane_b,
    output logic lane_a_oe,
    output logic lane_b_oe,
    output logic clk_out,
    output logic clk_oe
);

    logic                  viol;
    stage_t                tail;
    logic [LANE_COUNT-1:0] fmt;
    logic [LANE_COUNT-1:0] lanes;
    logic [LANE_COUNT-1:0] lanes_oe;

    bprx_polarity u_pol (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_pos (rx_pos),
        .sym_neg (rx_neg),
        .viol    (viol)
    );

    bprx_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .e3_mode (e3_mode),
        .sym_pos (rx_pos),
        .sym_neg (rx_neg),
        .viol    (viol),
        .tail    (tail)
    );

    always_comb begin
        fmt[0] = bin_mode ? tail.dat : tail.rp;
        fmt[1] = bin_mode ? tail.flg : tail.rn;
    end

    bprx_edge_out #(.WIDTH(LANE_COUNT)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_inv    (clk_inv),
        .out_en_n   (out_en_n),
        .fmt        (fmt),
        .lanes      (lanes),
        .lanes_oe   (lanes_oe),
        .clk_fwd    (clk_out),
        .clk_fwd_oe (clk_oe)
    );

    assign lane_a    = lanes[0];
    assign lane_b    = lanes[1];
    assign lane_a_oe = lanes_oe[0];
    assign lane_b_oe = lanes_oe[1];

endmodule

// File: rtl/bipolar_rx_formatter_chk.sv
`timescale 1ns/1ps
module bipolar_rx_formatter_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_pos,
    input logic rx_neg,
    input logic bin_mode,
    input logic e3_mode,
    input logic clk_inv,
    input logic out_en_n,
    input logic lane_a,
    input logic lane_b,
    input logic lane_a_oe,
    input logic lane_b_oe,
    input logic clk_out,
    input logic clk_oe
);

    logic [2:0] settle;
    logic [2:0] cfg_q;
    logic [2:0] cfg;
    logic       ready;

    assign cfg   = {bin_mode, e3_mode, clk_inv};
    assign ready = (settle == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle <= 3'd0;
            cfg_q  <= 3'd0;
        end else begin
            cfg_q <= cfg;
            if (cfg != cfg_q) begin
                settle <= 3'd0;
            end else if (settle != 3'd7) begin
                settle <= settle + 3'd1;
            end
        end
    end

    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !bin_mode && !clk_inv) |->
            (lane_a == $past(rx_pos, 4) && lane_b == $past(rx_neg, 4)));

    p_empty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bin_mode && !clk_inv && !$past(rx_pos || rx_neg, 4)) |-> !lane_a);

    p_flag_on_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bin_mode && lane_b) |-> lane_a);

    p_double_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bin_mode && !clk_inv && $past(rx_pos && rx_neg, 4)) |-> (lane_a && lane_b));

    p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_a_oe == !out_en_n) && (lane_b_oe == !out_en_n) && (clk_oe == !out_en_n));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lane_a && !lane_b));

endmodule

bind bipolar_rx_formatter bipolar_rx_formatter_chk u_chk (.*);

// File: tb/sim_bipolar_rx_formatter.sv
`timescale 1ns/1ps
module sim_bipolar_rx_formatter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic bin_mode = 1'b0;
    logic e3_mode = 1'b0;
    logic clk_inv = 1'b0;
    logic out_en_n = 1'b0;
    logic lane_a, lane_b, lane_a_oe, lane_b_oe, clk_out, clk_oe;

    typedef struct {
        int    due;
        logic  a;
        logic  b;
        string tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    lat = 4;
    int    checks = 0;
    int    errors = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bipolar_rx_formatter u0 (
        .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .bin_mode(bin_mode), .e3_mode(e3_mode), .clk_inv(clk_inv),
        .out_en_n(out_en_n), .lane_a(lane_a), .lane_b(lane_b),
        .lane_a_oe(lane_a_oe), .lane_b_oe(lane_b_oe),
        .clk_out(clk_out), .clk_oe(clk_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // driver: applies one bit and queues its expected lane pair
    task automatic send(input logic p, input logic n, input logic ea, input logic eb, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        rx_pos = p;
        rx_neg = n;
        it.due = cyc + lat;
        it.a   = ea;
        it.b   = eb;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) send(1'b0, 1'b0, 1'b0, 1'b0, "R2");
        wait (sb.size() == 0);
        @(posedge clk);
    endtask

    task automatic start(input logic bm, input logic e3, input logic inv);
        rst_n  = 1'b0;
        rx_pos = 1'b0;
        rx_neg = 1'b0;
        bin_mode = bm;
        e3_mode  = e3;
        clk_inv  = inv;
        lat = inv ? 5 : 4;
        sb.delete();
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check(lane_a == 1'b0 && lane_b == 1'b0, "R9 lanes after reset", {lane_a, lane_b}, 0);
    endtask

    // monitor: pops items as their due cycle arrives
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #3;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                it = sb.pop_front();
                if (it.due != cyc) begin
                    check(1'b0, {it.tag, " missed slot"}, cyc, it.due);
                end else begin
                    check({lane_a, lane_b} == {it.a, it.b}, it.tag, {lane_a, lane_b}, {it.a, it.b});
                end
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: pass-through lanes, falling-edge launch
        start(1'b0, 1'b0, 1'b0);
        send(1, 0, 1, 0, "R1");
        send(0, 0, 0, 0, "R1");
        send(0, 1, 0, 1, "R1");
        send(0, 1, 0, 1, "R1");
        send(1, 1, 1, 1, "R1");
        send(1, 0, 1, 0, "R1");
        drain();

        // R3 three-zero code: both substitution forms, then faults (R5, R6)
        start(1'b1, 1'b0, 1'b0);
        send(1, 0, 1, 0, "R2");
        send(0, 0, 0, 0, "R2");
        send(0, 1, 1, 0, "R2");
        send(0, 0, 0, 0, "R3");
        send(0, 0, 0, 0, "R3");
        send(0, 1, 0, 0, "R3 violation after two empties");
        send(1, 0, 0, 0, "R3 balancing mark");
        send(0, 0, 0, 0, "R3");
        send(1, 0, 0, 0, "R3 violation after balancing");
        send(0, 1, 1, 0, "R2");
        send(0, 1, 1, 1, "R5 adjacent violation");
        send(1, 1, 1, 1, "R6 double mark");
        send(0, 1, 1, 1, "R6 tracker held negative");
        drain();

        // R4 four-zero code: both forms, then a pattern only valid in the other code
        start(1'b1, 1'b1, 1'b0);
        send(1, 0, 1, 0, "R4 mark before substitution");
        send(0, 0, 0, 0, "R4");
        send(0, 0, 0, 0, "R4");
        send(0, 0, 0, 0, "R4");
        send(1, 0, 0, 0, "R4 violation after three empties");
        send(0, 1, 0, 0, "R4 balancing mark");
        send(0, 0, 0, 0, "R4");
        send(0, 0, 0, 0, "R4");
        send(0, 1, 0, 0, "R4 violation after balancing");
        send(1, 0, 1, 0, "R2");
        send(0, 0, 0, 0, "R2");
        send(1, 0, 1, 1, "R5 violation after one empty");
        drain();

        // R7 rising-edge launch adds half a cycle
        start(1'b1, 1'b1, 1'b1);
        send(1, 0, 1, 0, "R7");
        send(0, 0, 0, 0, "R7");
        send(0, 0, 0, 0, "R7");
        send(0, 0, 0, 0, "R7");
        send(1, 0, 0, 0, "R7");
        send(1, 0, 1, 1, "R7");
        drain();
        start(1'b0, 1'b0, 1'b1);
        send(0, 1, 0, 1, "R7");
        send(1, 0, 1, 0, "R7");
        drain();

        // R8: disabled outputs, decoder keeps tracking polarity
        start(1'b1, 1'b1, 1'b0);
        out_en_n = 1'b1;
        send(1, 0, 1, 0, "R8");
        #1;
        check(lane_a_oe == 1'b0 && lane_b_oe == 1'b0 && clk_oe == 1'b0, "R8 disabled",
              {lane_a_oe, lane_b_oe, clk_oe}, 0);
        send(0, 0, 0, 0, "R8");
        out_en_n = 1'b0;
        #1;
        check(lane_a_oe == 1'b1 && lane_b_oe == 1'b1 && clk_oe == 1'b1, "R8 enabled",
              {lane_a_oe, lane_b_oe, clk_oe}, 7);
        send(0, 0, 0, 0, "R8");
        send(0, 0, 0, 0, "R8");
        send(1, 0, 0, 0, "R8 substitution seen while disabled");
        drain();

        // R9: first mark after reset is never a violation
        start(1'b1, 1'b0, 1'b0);
        send(0, 1, 1, 0, "R9 first mark");
        drain();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule